// File: doc/BRIEF.md
# Keyboard Matrix Scan Encoder

The block walks a single active-high drive strobe across the rows of a key switch matrix, one row per host timing pulse, and reads the sense columns back. The first row that shows any high column stops the sweep. The lowest-numbered high column on that row is taken as the key. The key number, together with a modifier mode, is turned into a byte code. An active-low "data ready" flag then tells the host CPU that a byte is waiting. The host reads the byte by presenting a matching select pattern. The flag clears on the timing edge that falls during that read, and from that edge a second active-low flag marks that the key is still held, which supports software autorepeat.

When the key lifts, a digital counter must run a fixed number of timing pulses with the key open before scanning resumes. Any bounce of the key restarts that count. CONTROL and SHIFT are captured only while the sweep is running, so a change made while a key holds the sweep has no effect until scanning restarts. ALPHA is used at its live level. The timing pulse is the block's clock. The byte and its pad enable are presented to an external three-state buffer.

Top module: `kbd_scan_encoder`

## Requirements
- R1: During and right after synchronous reset, drive_o is one-hot on row 0, dav_n_o and rpt_n_o are 1, and bus_d_o is 0.
- R2: With no key closed, drive_o stays one-hot and moves from row r to row r+1 on each clock, wrapping from row N_DRV-1 to row 0.
- R3: When a sense bit is high on the driven row, the key index drive_row*N_SNS + column is captured, using the lowest high column when several are high. dav_n_o goes low on that edge, and drive_o stays on that row while the key is held and while the release count runs.
- R4: The byte is (key + 64*mode) mod 256. Mode encodings are normal=0, alpha=1, shift=2, control=3. Priority is: control when CONTROL=1; else shift when SHIFT=1; else alpha when ALPHA=1; else normal.
- R5: The device is selected when sel_hi_i==2'b11 and sel_lo_n_i==2'b00. bus_en_o is 1 exactly when selected, and bus_d_o then holds the captured byte. Any other select pattern leaves bus_en_o at 0 and dav_n_o unchanged.
- R6: A clock edge taken while selected returns dav_n_o to 1, unless a new key is captured on that same edge.
- R7: rpt_n_o is 1 before the read. It goes to 0 on the edge that clears dav_n_o while the key is still closed. It returns to 1 on the first edge that sees the key open.
- R8: After release, the next key on the still-driven row is captured on the (DEB_CYC+2)-th clock edge counted from the edge that first sees the key open.
- R9: A re-closure of the held key during the release count restarts the count. A key captured after the final opening then appears on the (DEB_CYC+1)-th edge after that opening.
- R10: CONTROL and SHIFT are sampled only on clocks spent scanning. A change made while a key holds the scan is not used by a key captured on the first scan clock after the release count. ALPHA is used at its level on the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host timing pulse; rising edge scans and updates flags |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | N_SNS | Column sense lines, high when a switch on the driven row is closed |
| ctrl_i | input | 1 | CONTROL modifier key |
| shift_i | input | 1 | SHIFT modifier key |
| alpha_i | input | 1 | ALPHA lock level |
| sel_hi_i | input | 2 | Select inputs, active high |
| sel_lo_n_i | input | 2 | Select inputs, active low |
| drive_o | output | N_DRV | One-hot row drive strobe |
| bus_d_o | output | 8 | Captured key byte toward the three-state buffer |
| bus_en_o | output | 1 | Three-state buffer enable |
| dav_n_o | output | 1 | Data ready flag, active low |
| rpt_n_o | output | 1 | Key still held after read, active low |

## Verification
The hardest situations to reach are the release count and modifier capture, because they happen while the sweep is frozen. The bench reaches them by moving the key on the same row the strobe is parked on. It opens the held key and closes a neighbour in that row in the same cycle, so capture happens on the very first scan clock. That makes the edge count exact and leaves the modifier latch holding its value from before the hold. A single-cycle re-closure of the held key partway through the count exercises the restart. Around this, every key is swept against all eight modifier combinations and every wrong select pattern.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ALPHA   = 2'd1,
    MODE_SHIFT   = 2'd2,
    MODE_CONTROL = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_HELD = 2'd1,
    ST_DEB  = 2'd2
  } scan_st_e;

  // Replaceable code map: key index offset by 64 per mode step.
  function automatic logic [7:0] key_code(input logic [7:0] key, input mode_e m);
    return key + {m, 6'b0};
  endfunction
endpackage

// File: rtl/kbd_drive_seq.sv
module kbd_drive_seq #(
  parameter int N_DRV = 11,
  parameter int DRV_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  output logic [DRV_W-1:0] idx_o,
  output logic [N_DRV-1:0] drive_o
);
  localparam logic [DRV_W-1:0] LAST = DRV_W'(N_DRV - 1);

  logic [DRV_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (adv_i) begin
      if (idx_q == LAST) idx_q <= '0;
      else               idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N_DRV; g++) begin : g_row
    assign drive_o[g] = (idx_q == DRV_W'(g));
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/kbd_sense_pick.sv
module kbd_sense_pick #(
  parameter int N_SNS = 8,
  parameter int SNS_W = (N_SNS > 1) ? $clog2(N_SNS) : 1
) (
  input  logic [N_SNS-1:0] sense_i,
  output logic             hit_o,
  output logic [SNS_W-1:0] col_o
);
  always_comb begin
    col_o = '0;
    for (int i = N_SNS - 1; i >= 0; i--) begin
      if (sense_i[i]) col_o = SNS_W'(i);
    end
  end

  assign hit_o = |sense_i;
endmodule

// File: rtl/kbd_mod_latch.sv
module kbd_mod_latch
  import kbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  logic  ctrl_i,
  input  logic  shift_i,
  input  logic  alpha_i,
  output mode_e mode_o
);
  logic ctrl_q, shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 1'b0;
      shift_q <= 1'b0;
    end else if (load_i) begin
      ctrl_q  <= ctrl_i;
      shift_q <= shift_i;
    end
  end

  always_comb begin
    if (ctrl_q)       mode_o = MODE_CONTROL;
    else if (shift_q) mode_o = MODE_SHIFT;
    else if (alpha_i) mode_o = MODE_ALPHA;
    else              mode_o = MODE_NORMAL;
  end
endmodule

// File: rtl/kbd_scan_ctl.sv
module kbd_scan_ctl
  import kbd_pkg::*;
#(
  parameter int N_DRV   = 11,
  parameter int N_SNS   = 8,
  parameter int DEB_CYC = 16,
  parameter int DRV_W   = (N_DRV > 1) ? $clog2(N_DRV) : 1,
  parameter int SNS_W   = (N_SNS > 1) ? $clog2(N_SNS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SNS-1:0] sense_i,
  input  logic             hit_i,
  input  logic [SNS_W-1:0] col_i,
  input  logic [DRV_W-1:0] row_i,
  input  mode_e            mode_i,
  input  logic             sel_ok_i,
  output logic             adv_o,
  output logic             mod_load_o,
  output scan_st_e         st_o,
  output logic [7:0]       code_o,
  output logic             dav_n_o,
  output logic             rpt_n_o
);
  localparam int CNT_W = $clog2(DEB_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEB_CYC - 1);

  scan_st_e         st_q, st_d;
  logic [SNS_W-1:0] col_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       code_q;
  logic             dav_n_q, dav_n_d, rpt_n_q;
  logic             take, held;
  logic [7:0]       key_w;

  assign take  = (st_q == ST_SCAN) && hit_i;
  assign held  = sense_i[col_q];
  assign key_w = 8'(int'(row_i) * N_SNS + int'(col_i));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_SCAN: if (hit_i) st_d = ST_HELD;
      ST_HELD: if (!held) begin
        st_d  = ST_DEB;
        cnt_d = CNT_TOP;
      end
      ST_DEB: begin
        if (held)               cnt_d = CNT_TOP;
        else if (cnt_q == '0)   st_d  = ST_SCAN;
        else                    cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_SCAN;
    endcase
  end

  always_comb begin
    dav_n_d = dav_n_q;
    if (take)          dav_n_d = 1'b0;
    else if (sel_ok_i) dav_n_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_SCAN;
      cnt_q   <= '0;
      col_q   <= '0;
      code_q  <= '0;
      dav_n_q <= 1'b1;
      rpt_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      dav_n_q <= dav_n_d;
      rpt_n_q <= !((st_d == ST_HELD) && dav_n_d);
      if (take) begin
        col_q  <= col_i;
        code_q <= key_code(key_w, mode_i);
      end
    end
  end

  assign adv_o      = (st_q == ST_SCAN) && !hit_i;
  assign mod_load_o = (st_q == ST_SCAN);
  assign st_o       = st_q;
  assign code_o     = code_q;
  assign dav_n_o    = dav_n_q;
  assign rpt_n_o    = rpt_n_q;
endmodule

// File: rtl/kbd_scan_encoder.sv
module kbd_scan_encoder
  import kbd_pkg::*;
#(
  parameter int N_DRV   = 11,
  parameter int N_SNS   = 8,
  parameter int DEB_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SNS-1:0] sense_i,
  input  logic             ctrl_i,
  input  logic             shift_i,
  input  logic             alpha_i,
  input  logic [1:0]       sel_hi_i,
  input  logic [1:0]       sel_lo_n_i,
  output logic [N_DRV-1:0] drive_o,
  output logic [7:0]       bus_d_o,
  output logic             bus_en_o,
  output logic             dav_n_o,
  output logic             rpt_n_o
);
  localparam int DRV_W = (N_DRV > 1) ? $clog2(N_DRV) : 1;
  localparam int SNS_W = (N_SNS > 1) ? $clog2(N_SNS) : 1;

  logic [DRV_W-1:0] row_w;
  logic [SNS_W-1:0] col_w;
  logic             hit_w, adv_w, load_w, sel_ok;
  mode_e            mode_w;
  scan_st_e         st_w;

  assign sel_ok = (&sel_hi_i) && !(|sel_lo_n_i);

  kbd_drive_seq #(.N_DRV(N_DRV), .DRV_W(DRV_W)) u_drv (
    .clk(clk), .rst(rst), .adv_i(adv_w), .idx_o(row_w), .drive_o(drive_o)
  );

  kbd_sense_pick #(.N_SNS(N_SNS), .SNS_W(SNS_W)) u_pick (
    .sense_i(sense_i), .hit_o(hit_w), .col_o(col_w)
  );

  kbd_mod_latch u_mod (
    .clk(clk), .rst(rst), .load_i(load_w), .ctrl_i(ctrl_i),
    .shift_i(shift_i), .alpha_i(alpha_i), .mode_o(mode_w)
  );

  kbd_scan_ctl #(
    .N_DRV(N_DRV), .N_SNS(N_SNS), .DEB_CYC(DEB_CYC), .DRV_W(DRV_W), .SNS_W(SNS_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .sense_i(sense_i), .hit_i(hit_w), .col_i(col_w),
    .row_i(row_w), .mode_i(mode_w), .sel_ok_i(sel_ok), .adv_o(adv_w),
    .mod_load_o(load_w), .st_o(st_w), .code_o(bus_d_o),
    .dav_n_o(dav_n_o), .rpt_n_o(rpt_n_o)
  );

  assign bus_en_o = sel_ok;
endmodule

// File: rtl/kbd_scan_encoder_chk.sv
module kbd_scan_encoder_chk
  import kbd_pkg::*;
#(
  parameter int N_DRV = 11,
  parameter int N_SNS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SNS-1:0] sense_i,
  input logic [1:0]       sel_hi_i,
  input logic [1:0]       sel_lo_n_i,
  input logic [N_DRV-1:0] drive_o,
  input logic             dav_n_o,
  input logic             rpt_n_o,
  input scan_st_e         st
);
  logic sel;
  assign sel = (sel_hi_i == 2'b11) && (sel_lo_n_i == 2'b00);

  a_r2_drive_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(drive_o));

  a_r3_row_frozen: assert property (@(posedge clk) disable iff (rst)
    (st != ST_SCAN) |=> $stable(drive_o));

  a_r3_dav_needs_sense: assert property (@(posedge clk) disable iff (rst)
    $fell(dav_n_o) |-> $past(|sense_i));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (!dav_n_o && sel && st != ST_SCAN) |=> dav_n_o);

  a_r7_rpt_after_read: assert property (@(posedge clk) disable iff (rst)
    !rpt_n_o |-> dav_n_o);
endmodule

bind kbd_scan_encoder kbd_scan_encoder_chk #(.N_DRV(N_DRV), .N_SNS(N_SNS)) u_chk (
  .clk(clk), .rst(rst), .sense_i(sense_i), .sel_hi_i(sel_hi_i),
  .sel_lo_n_i(sel_lo_n_i), .drive_o(drive_o), .dav_n_o(dav_n_o),
  .rpt_n_o(rpt_n_o), .st(st_w)
);

// File: tb/sim_kbd_scan_encoder.sv
`timescale 1ns/1ps
module sim_kbd_scan_encoder;
  localparam int ND  = 11;
  localparam int NS  = 8;
  localparam int DEB = 5;
  localparam int NK  = ND * NS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] sense;
  logic          ctrl = 0, shift = 0, alpha = 0;
  logic [1:0]    sel_hi = 2'b00, sel_lo_n = 2'b11;
  logic [ND-1:0] drive;
  logic [7:0]    bus_d;
  logic          bus_en, dav_n, rpt_n;
  logic          pressed [NK];

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kbd_scan_encoder #(.N_DRV(ND), .N_SNS(NS), .DEB_CYC(DEB)) u0 (
    .clk(clk), .rst(rst), .sense_i(sense), .ctrl_i(ctrl), .shift_i(shift),
    .alpha_i(alpha), .sel_hi_i(sel_hi), .sel_lo_n_i(sel_lo_n), .drive_o(drive),
    .bus_d_o(bus_d), .bus_en_o(bus_en), .dav_n_o(dav_n), .rpt_n_o(rpt_n)
  );

  always_comb begin
    sense = '0;
    for (int k = 0; k < NK; k++)
      if (pressed[k] && drive[k / NS]) sense[k % NS] = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic int mode_of(input bit c, input bit s, input bit a);
    if (c) return 3;
    if (s) return 2;
    if (a) return 1;
    return 0;
  endfunction

  function automatic int code_of(input int key, input int m);
    return (key + 64 * m) % 256;
  endfunction

  task automatic wait_dav(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (dav_n && n < 40);
  endtask

  task automatic do_read(input int exp_code, input string req);
    sel_hi = 2'b11; sel_lo_n = 2'b00;
    #0.5;
    chk(bus_en == 1'b1, "R5", bus_en, 1);
    chk(int'(bus_d) == exp_code, req, bus_d, exp_code);
    @(posedge clk); @(negedge clk);
    chk(dav_n == 1'b1, "R6", dav_n, 1);
    chk(rpt_n == 1'b0, "R7", rpt_n, 0);
    sel_hi = 2'b00; sel_lo_n = 2'b11;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, prev, cur, key, m, a_key, b_key;
    for (int k = 0; k < NK; k++) pressed[k] = 1'b0;
    cyc(3);
    // R1: reset state
    chk(drive == 1, "R1", drive, 1);
    chk(dav_n == 1 && rpt_n == 1, "R1", {dav_n, rpt_n}, 3);
    chk(bus_d == 0 && bus_en == 0, "R1", bus_d, 0);
    rst = 1'b0;

    // R2: free running scan, wrap
    prev = $clog2(drive);
    for (int i = 0; i < 2 * ND + 3; i++) begin
      cyc(1);
      cur = $clog2(drive);
      chk($onehot(drive) && cur == (prev + 1) % ND, "R2", cur, (prev + 1) % ND);
      prev = cur;
    end

    // R3, R4: sweep all keys against all modifier combinations
    for (int k = 0; k < NK; k++) begin
      for (int c = 0; c < 8; c++) begin
        ctrl = c[2]; shift = c[1]; alpha = c[0];
        cyc(2);
        pressed[k] = 1'b1;
        wait_dav(n);
        chk(dav_n == 1'b0, "R3", dav_n, 0);
        chk(drive == (ND'(1) << (k / NS)), "R3", drive, k / NS);
        chk(rpt_n == 1'b1, "R7", rpt_n, 1);
        do_read(code_of(k, mode_of(c[2], c[1], c[0])), "R4");
        pressed[k] = 1'b0;
        cyc(1);
        chk(rpt_n == 1'b1, "R7", rpt_n, 1);
        cyc(DEB + 3);
      end
    end
    ctrl = 0; shift = 0; alpha = 0;
    cyc(2);

    // R3: lowest column wins on one row
    pressed[6 * NS + 7] = 1'b1; pressed[6 * NS + 2] = 1'b1;
    wait_dav(n);
    cyc(3);
    chk(drive == (ND'(1) << 6), "R3", drive, 6);
    // R5: wrong select patterns
    for (int p = 0; p < 16; p++) begin
      if (p == 4'b1100) continue;
      sel_hi = p[3:2]; sel_lo_n = p[1:0];
      #0.5;
      chk(bus_en == 1'b0, "R5", bus_en, 0);
      @(posedge clk); @(negedge clk);
      chk(dav_n == 1'b0, "R5", dav_n, 0);
    end
    sel_hi = 2'b00; sel_lo_n = 2'b11;
    do_read(code_of(6 * NS + 2, 0), "R3");
    pressed[6 * NS + 7] = 1'b0; pressed[6 * NS + 2] = 1'b0;
    cyc(DEB + 4);

    // R8: exact release count
    a_key = 3 * NS + 1; b_key = 3 * NS + 5;
    pressed[a_key] = 1'b1;
    wait_dav(n);
    do_read(code_of(a_key, 0), "R4");
    pressed[a_key] = 1'b0; pressed[b_key] = 1'b1;
    wait_dav(n);
    chk(n == DEB + 2, "R8", n, DEB + 2);
    do_read(code_of(b_key, 0), "R8");
    pressed[b_key] = 1'b0;
    cyc(DEB + 4);

    // R9: bounce restarts the count
    pressed[a_key] = 1'b1;
    wait_dav(n);
    do_read(code_of(a_key, 0), "R4");
    pressed[a_key] = 1'b0;
    cyc(2);
    pressed[a_key] = 1'b1;
    cyc(1);
    pressed[a_key] = 1'b0; pressed[b_key] = 1'b1;
    wait_dav(n);
    chk(n == DEB + 1, "R9", n, DEB + 1);
    do_read(code_of(b_key, 0), "R9");
    pressed[b_key] = 1'b0;
    cyc(DEB + 4);

    // R10: CONTROL/SHIFT changed during hold are not seen
    a_key = 2 * NS + 0; b_key = 2 * NS + 4;
    pressed[a_key] = 1'b1;
    wait_dav(n);
    do_read(code_of(a_key, 0), "R10");
    ctrl = 1; shift = 1;
    cyc(2);
    pressed[a_key] = 1'b0; pressed[b_key] = 1'b1;
    wait_dav(n);
    do_read(code_of(b_key, 0), "R10");
    pressed[b_key] = 1'b0;
    cyc(DEB + 4);
    ctrl = 0; shift = 0;
    cyc(3);
    // R10: ALPHA is taken live
    pressed[a_key] = 1'b1;
    wait_dav(n);
    do_read(code_of(a_key, 0), "R10");
    alpha = 1;
    cyc(2);
    pressed[a_key] = 1'b0; pressed[b_key] = 1'b1;
    wait_dav(n);
    do_read(code_of(b_key, 1), "R10");
    pressed[b_key] = 1'b0;
    alpha = 0;
    cyc(DEB + 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule